// File: doc/BRIEF.md
# Counted Three-Wire Control Word Loader

This block receives a fixed-length control word over three slow serial lines: a data line, a serial clock and a load strobe. The lines are synchronised into the system clock domain. Each rising serial clock edge shifts one data bit into a staging register, most significant bit first. A bit counter stops accepting bits once a whole word has arrived and ignores any clock edges that follow. A rising edge on the load line copies the staged word into the working control register. The new settings take effect at once and the counter starts over.

The working register drives the decoded settings: four synthesiser divider values, a set of receive-path and filter option bits, a two-bit modulation selector, a transmit/receive select and a power-down bit. A power-amplifier enable is kept low after every load. It goes high only when the word that follows a transmit, powered-up word has been fully clocked in. This lets the frequency synthesiser settle before the amplifier switches on. With default parameters the word is 59 bits: two 12-bit dividers, two 10-bit dividers and a 15-bit option tail that contains two fixed-zero positions.

Top module: `scw_serial_ctrl`

## Requirements
- R1: Bit positions are counted p1..p59, where p1 is the first bit shifted in. Divider A (`div_n1`) is p1-p12, divider B (`div_n0`) is p13-p24, divider C (`div_m1`) is p25-p34 and divider D (`div_m0`) is p35-p44. In each field the earlier bit is the more significant.
- R2: Option bits: `lna_bypass` = p45, `dig_out_en` = p47, `dig_iq_sel` = p48, `rc_fc[0]` = p49, `rc_fc[1]` = p50, `rect_src` = p51, `if_out_src` = p52, `bias_share` = p53, `gm_bias` = p55, `mod_sel[1]` = p56, `mod_sel[0]` = p57, `tx_mode` = p58 (1 = transmit), `power_down` = p59. p46 and p54 are fixed zero and drive no output.
- R3: After a load, exactly 59 rising serial clock edges are accepted. Later edges are discarded, so extra bits never reach the committed word.
- R4: The decoded outputs change only on a load edge, and they then take the value of the staged word.
- R5: A load edge restarts the count, so the next word begins with the first rising serial clock edge after it. `word_done` rises when the 59th bit is accepted and is cleared by a load.
- R6: `pa_en` is low after every load. It rises when the next word has been fully accepted, and only if the committed word has `tx_mode` = 1 and `power_down` = 0. Otherwise it stays low.
- R7: After reset, all decoded outputs are zero except `power_down`, which is 1, and `pa_en` and `word_done` are low. Serial clock edges are ignored until the first load. The first load therefore commits an all-zero staged word.
- R8: If a load edge and a serial clock rising edge reach the logic in the same system cycle, the load takes effect and that clock edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_load | input | 1 | Load strobe line (asynchronous) |
| div_n1 | output | N_W | Divider A |
| div_n0 | output | N_W | Divider B |
| div_m1 | output | M_W | Divider C |
| div_m0 | output | M_W | Divider D |
| lna_bypass | output | 1 | Front-end amplifier bypass |
| dig_out_en | output | 1 | Digital channel output enable |
| dig_iq_sel | output | 1 | Channel select for the digital output (1 = I) |
| rc_fc | output | 2 | RC filter cut-off code {p50, p49} |
| rect_src | output | 1 | Rectifier source select |
| if_out_src | output | 1 | Analog channel output source select |
| bias_share | output | 1 | Shared filter bias select |
| gm_bias | output | 1 | Wide-deviation filter bias |
| mod_sel | output | 2 | Modulation selector {p56, p57} |
| tx_mode | output | 1 | 1 = transmit, 0 = receive |
| power_down | output | 1 | 1 = powered down |
| pa_en | output | 1 | Power-amplifier enable |
| word_done | output | 1 | Full word accepted since last load |

## Verification
The bench uses the default parameters: 12-bit and 10-bit dividers and two synchroniser stages. This gives a 59-bit word, so every field boundary of R1 and R2 sits at its real position. The serial lines are held for several system cycles per level, so each edge survives synchronisation. At this word length the counter is driven into saturation with up to five surplus clock edges. The amplifier enable is exercised for transmit, receive and powered-down words. A load edge is made to coincide with a clock edge through the shared synchroniser depth.

// File: rtl/scw_pkg.sv
package scw_pkg;

  // Option tail layout: fixed length, positions matter to downstream decode.
  localparam int TAIL_W  = 15;
  localparam int RSVD_HI = 13;  // p46, fixed zero
  localparam int RSVD_LO = 5;   // p54, fixed zero
  localparam int KEEP_W  = TAIL_W - 2;

  typedef struct packed {
    logic lna_bypass;
    logic dig_out_en;
    logic dig_iq_sel;
    logic fc0;
    logic fc1;
    logic rect_src;
    logic if_out_src;
    logic bias_share;
    logic gm_bias;
    logic mod1;
    logic mod0;
    logic tx;
    logic pd;
  } scw_flags_t;

  function automatic int word_len(input int n_w, input int m_w);
    return 2 * n_w + 2 * m_w + TAIL_W;
  endfunction

  function automatic int cnt_width(input int len);
    return $clog2(len + 1);
  endfunction

endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
  parameter int WORD_W = 59
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_fire,
  input  logic                          load_fire,
  input  logic                          bit_i,
  output logic [WORD_W-3:0]             payload_o,
  output logic                          accept_o,
  output logic                          last_bit_o,
  output logic                          full_o,
  output logic                          armed_o
);
  import scw_pkg::*;
  localparam int CNT_W = cnt_width(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              armed;

  // Load has priority; shifting only while armed and short of a full word.
  assign accept_o   = shift_fire && !load_fire && armed && (cnt != CNT_MAX);
  assign last_bit_o = accept_o && (cnt == CNT_MAX - 1'b1);
  assign full_o     = armed && (cnt == CNT_MAX);
  assign armed_o    = armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load_fire) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (accept_o) begin
      shreg <= {shreg[WORD_W-2:0], bit_i};
      cnt   <= cnt + 1'b1;
    end
  end

  // Drop the two fixed-zero positions of the option tail.
  assign payload_o = {shreg[WORD_W-1:RSVD_HI+1],
                      shreg[RSVD_HI-1:RSVD_LO+1],
                      shreg[RSVD_LO-1:0]};
endmodule

// File: rtl/scw_ctrl_reg.sv
module scw_ctrl_reg #(
  parameter int PAY_W = 57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic             last_bit,
  input  logic [PAY_W-1:0] payload_i,
  output logic [PAY_W-1:0] held_o,
  output logic             pa_en_o
);
  import scw_pkg::*;
  localparam logic [PAY_W-1:0] HELD_RST = PAY_W'(1);  // only power-down set

  scw_flags_t flags;
  assign flags = scw_flags_t'(held_o[KEEP_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o  <= HELD_RST;
      pa_en_o <= 1'b0;
    end else if (load_fire) begin
      held_o  <= payload_i;
      pa_en_o <= 1'b0;
    end else if (last_bit && flags.tx && !flags.pd) begin
      pa_en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/scw_serial_ctrl.sv
module scw_serial_ctrl #(
  parameter int N_W         = 12,
  parameter int M_W         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [N_W-1:0] div_n1,
  output logic [N_W-1:0] div_n0,
  output logic [M_W-1:0] div_m1,
  output logic [M_W-1:0] div_m0,
  output logic           lna_bypass,
  output logic           dig_out_en,
  output logic           dig_iq_sel,
  output logic [1:0]     rc_fc,
  output logic           rect_src,
  output logic           if_out_src,
  output logic           bias_share,
  output logic           gm_bias,
  output logic [1:0]     mod_sel,
  output logic           tx_mode,
  output logic           power_down,
  output logic           pa_en,
  output logic           word_done
);
  import scw_pkg::*;
  localparam int WORD_W = word_len(N_W, M_W);
  localparam int PAY_W  = WORD_W - 2;

  logic [2:0] lines_s;
  logic       sclk_q, load_q;
  logic       shift_fire, load_fire, shift_accept, last_bit, armed;
  logic [PAY_W-1:0] payload, held;
  scw_flags_t f;

  scw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_load, ser_clk, ser_data}), .q(lines_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      sclk_q <= lines_s[1];
      load_q <= lines_s[2];
    end
  end

  assign shift_fire = lines_s[1] && !sclk_q;
  assign load_fire  = lines_s[2] && !load_q;

  scw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_fire(shift_fire), .load_fire(load_fire), .bit_i(lines_s[0]),
    .payload_o(payload), .accept_o(shift_accept), .last_bit_o(last_bit),
    .full_o(word_done), .armed_o(armed)
  );

  scw_ctrl_reg #(.PAY_W(PAY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .load_fire(load_fire), .last_bit(last_bit),
    .payload_i(payload), .held_o(held), .pa_en_o(pa_en)
  );

  assign {div_n1, div_n0, div_m1, div_m0} = held[PAY_W-1:KEEP_W];
  assign f          = scw_flags_t'(held[KEEP_W-1:0]);
  assign lna_bypass = f.lna_bypass;
  assign dig_out_en = f.dig_out_en;
  assign dig_iq_sel = f.dig_iq_sel;
  assign rc_fc      = {f.fc1, f.fc0};
  assign rect_src   = f.rect_src;
  assign if_out_src = f.if_out_src;
  assign bias_share = f.bias_share;
  assign gm_bias    = f.gm_bias;
  assign mod_sel    = {f.mod1, f.mod0};
  assign tx_mode    = f.tx;
  assign power_down = f.pd;
endmodule

// File: rtl/scw_serial_ctrl_chk.sv
module scw_serial_ctrl_chk #(
  parameter int PAY_W = 57
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_fire,
  input logic             armed,
  input logic             word_done,
  input logic             pa_en,
  input logic             tx_mode,
  input logic             power_down,
  input logic [PAY_W-1:0] held
);
  AST_DONE_CLEARED_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !word_done); // R5
  AST_LOAD_ARMS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> armed); // R5
  AST_DONE_HOLDS_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !load_fire |=> word_done); // R3
  AST_HELD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(held)); // R4
  AST_PA_LOW_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !pa_en); // R6
  AST_PA_NEEDS_ACTIVE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> tx_mode && !power_down); // R6
  AST_PA_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_en) |-> word_done); // R6
  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> power_down && !pa_en && !word_done); // R7
endmodule

bind scw_serial_ctrl scw_serial_ctrl_chk #(.PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .armed(armed),
  .word_done(word_done), .pa_en(pa_en), .tx_mode(tx_mode),
  .power_down(power_down), .held(held)
);

// File: tb/scw_serial_ctrl_test.sv
module scw_serial_ctrl_test;
  localparam int W    = 59;
  localparam int HOLD = 6;
  localparam int NV   = 5;

  // Vectors: {A, B, C, D, tail p45..p59}
  localparam logic [W-1:0] VEC [NV] = '{
    {12'd518, 12'd697, 10'd191, 10'd257, 15'b0_0_1_0_1_0_1_0_1_0_1_1_0_1_0},
    {12'hABC, 12'h123, 10'h3FF, 10'h001, 15'b1_0_0_1_0_1_0_1_0_0_0_0_1_0_0},
    {12'hFFF, 12'h000, 10'h155, 10'h2AA, 15'b0_0_1_1_1_1_1_1_1_0_1_1_1_1_0},
    {12'h5A5, 12'hC3C, 10'h0F0, 10'h30F, 15'b1_0_1_0_0_1_1_0_0_0_1_0_1_1_1},
    {12'h001, 12'h800, 10'h200, 10'h000, 15'b0_0_0_0_0_0_0_0_0_0_0_0_0_0_0}
  };
  localparam int XTRA [NV] = '{3, 0, 5, 1, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [11:0] div_n1, div_n0;
  logic [9:0]  div_m1, div_m0;
  logic lna_bypass, dig_out_en, dig_iq_sel, rect_src, if_out_src;
  logic bias_share, gm_bias, tx_mode, power_down, pa_en, word_done;
  logic [1:0] rc_fc, mod_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scw_serial_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .div_n1(div_n1), .div_n0(div_n0), .div_m1(div_m1),
    .div_m0(div_m0), .lna_bypass(lna_bypass), .dig_out_en(dig_out_en),
    .dig_iq_sel(dig_iq_sel), .rc_fc(rc_fc), .rect_src(rect_src),
    .if_out_src(if_out_src), .bias_share(bias_share), .gm_bias(gm_bias),
    .mod_sel(mod_sel), .tx_mode(tx_mode), .power_down(power_down),
    .pa_en(pa_en), .word_done(word_done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_clk = 1'b0; ser_data = b;
    wait_cyc(HOLD);
    ser_clk = 1'b1;
    wait_cyc(HOLD);
  endtask

  task automatic pulse_load();
    ser_clk = 1'b0;
    ser_load = 1'b1;
    wait_cyc(HOLD);
    ser_load = 1'b0;
    wait_cyc(HOLD);
  endtask

  // Bench-side view of the decoded outputs, ordered by p-number.
  function automatic logic [43:0] got_divs();
    return {div_n1, div_n0, div_m1, div_m0};
  endfunction
  function automatic logic [12:0] got_flags();
    return {lna_bypass, dig_out_en, dig_iq_sel, rc_fc[0], rc_fc[1], rect_src,
            if_out_src, bias_share, gm_bias, mod_sel[1], mod_sel[0],
            tx_mode, power_down};
  endfunction
  function automatic logic [12:0] exp_flags(input logic [W-1:0] w);
    return {w[14], w[12:6], w[4:0]};
  endfunction

  task automatic check_word(input string req, input logic [W-1:0] w);
    check(req == "" ? "R1" : req, "dividers", 64'(got_divs()), 64'(w[58:15]));
    check(req == "" ? "R2" : req, "options", 64'(got_flags()), 64'(exp_flags(w)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cmt;
    logic [W-1:0] a_word;
    wait_cyc(4);
    // R7: reset state
    check("R7", "dividers after reset", 64'(got_divs()), 64'd0);
    check("R7", "options after reset", 64'(got_flags()), 64'd1);
    check("R7", "pa_en after reset", 64'(pa_en), 64'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R7", "word_done after reset", 64'(word_done), 64'd0);
    // R7: clocks before the first load are ignored
    for (int i = 0; i < W; i++) ser_bit(1'b1);
    check("R7", "word_done stays low before load", 64'(word_done), 64'd0);
    check("R7", "outputs unchanged before load", 64'(power_down), 64'd1);
    pulse_load();
    check("R7", "first load commits zeros dividers", 64'(got_divs()), 64'd0);
    check("R7", "first load commits zeros options", 64'(got_flags()), 64'd0);
    cmt = '0;

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      for (int i = W - 1; i >= 1; i--) ser_bit(VEC[v][i]);
      check("R5", "word_done before last bit", 64'(word_done), 64'd0);
      check("R6", "pa_en before last bit", 64'(pa_en), 64'd0);
      ser_bit(VEC[v][0]);
      for (int k = 0; k < XTRA[v]; k++) ser_bit(~VEC[v][0]);
      check("R5", "word_done after full word", 64'(word_done), 64'd1);
      check("R6", "pa_en after next word", 64'(pa_en), 64'(cmt[1] & ~cmt[0]));
      check("R4", "outputs hold until load", 64'(got_divs()), 64'(cmt[58:15]));
      pulse_load();
      check_word("", VEC[v]);  // R1 R2, and R3 via surplus clocks
      check("R5", "word_done cleared by load", 64'(word_done), 64'd0);
      check("R6", "pa_en low after load", 64'(pa_en), 64'd0);
      cmt = VEC[v];
    end

    // R8: load and clock edge together; clock edge discarded
    a_word = VEC[0];
    for (int i = W - 1; i >= 0; i--) ser_bit(a_word[i]);
    pulse_load();
    ser_clk = 1'b0; ser_data = 1'b1;
    wait_cyc(HOLD);
    ser_load = 1'b1; ser_clk = 1'b1;
    wait_cyc(HOLD);
    ser_load = 1'b0;
    wait_cyc(HOLD);
    ser_clk = 1'b0;
    wait_cyc(HOLD);
    pulse_load();
    check_word("R8", a_word);
    for (int i = 0; i < W - 1; i++) ser_bit(1'b0);
    check("R8", "count restarted, 58 bits not done", 64'(word_done), 64'd0);
    ser_bit(1'b0);
    check("R3", "59th bit completes word", 64'(word_done), 64'd1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule